// File: doc/BRIEF.md
# In-Order Pipeline Hazard Controller

This block decides, every cycle, which stages of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) move forward, which keep their contents, and which receive an empty slot. It looks at the register numbers that the decode stage wants to read and at the destination registers of the execute and memory stages. It also watches three event inputs: a busy flag from a multi-cycle execute unit such as a divider, a wait flag from the memory stage, and a taken-branch flag from execute. From these it drives hold, flush and bubble controls for the datapath.

The block also chooses the operand source for each decode read. It can use the register file, the result that sits one instruction ahead, or the result that sits two instructions ahead. The choice is made while the consumer is in decode and registered, so it is stable while that consumer runs in execute. By then the producers have moved one stage on, into memory and write-back. A load that feeds the very next instruction cannot be forwarded in time, so that case costs one interlock cycle.

Top module: `hz_ctrl`

## Requirements
- R1: After synchronous reset, both forwarding selects read 0 (register file).
- R2: When a used decode source matches the destination of a valid, writing execute-stage instruction, that operand's select takes value 1 (memory-stage result) at the next clock edge on which execute accepts a new instruction.
- R3: When a used decode source matches a valid, writing memory-stage destination and does not match the execute stage, the select takes value 2 (write-back result). When both stages match, the execute stage (the younger producer) wins with value 1.
- R4: A source that is unused, or that matches only stages that are invalid or do not write, gets select 0.
- R5: With ZERO_SKIP=0, register 0 is forwarded like any other register. With ZERO_SKIP=1, a source of register 0 always gets select 0.
- R6: A valid, writing load in execute whose destination matches a used source of a valid decode instruction asserts hold_if and hold_d and bubble_e, and leaves execute free to advance.
- R7: An asserted execute-busy flag, with no memory wait, holds fetch, decode and execute and inserts a bubble into memory, while the memory stage advances.
- R8: A memory wait holds all four stages from fetch to memory and inserts a bubble into write-back. It suppresses every flush and every other bubble.
- R9: A taken branch in a valid execute stage that is not held flushes fetch and decode, and does not hold either of them. While execute is held, the branch has no effect.
- R10: While execute is held, both forwarding selects keep their values.
- R11: When execute accepts an empty slot (decode invalid, decode flushed, or a load-use bubble), both selects become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_valid_i | input | 1 | Decode stage holds a live instruction |
| d_rs1_i | input | REG_W | First source register number in decode |
| d_rs1_use_i | input | 1 | First source is read |
| d_rs2_i | input | REG_W | Second source register number in decode |
| d_rs2_use_i | input | 1 | Second source is read |
| e_valid_i | input | 1 | Execute stage holds a live instruction |
| e_rd_i | input | REG_W | Execute-stage destination register |
| e_we_i | input | 1 | Execute-stage instruction writes a register |
| e_load_i | input | 1 | Execute-stage instruction is a load |
| e_busy_i | input | 1 | Multi-cycle execute operation still running |
| e_br_taken_i | input | 1 | Execute resolved a taken branch |
| m_valid_i | input | 1 | Memory stage holds a live instruction |
| m_rd_i | input | REG_W | Memory-stage destination register |
| m_we_i | input | 1 | Memory-stage instruction writes a register |
| m_wait_i | input | 1 | Memory access not finished this cycle |
| hold_if_o | output | 1 | Fetch keeps its contents |
| hold_d_o | output | 1 | Decode keeps its contents |
| hold_e_o | output | 1 | Execute keeps its contents |
| hold_m_o | output | 1 | Memory keeps its contents |
| flush_if_o | output | 1 | Clear fetch valid (branch) |
| flush_d_o | output | 1 | Clear decode valid (branch) |
| bubble_e_o | output | 1 | Execute receives an empty slot |
| bubble_m_o | output | 1 | Memory receives an empty slot |
| bubble_wb_o | output | 1 | Write-back receives an empty slot |
| fwd_a_o | output | 2 | First operand source: 0 file, 1 memory, 2 write-back |
| fwd_b_o | output | 2 | Second operand source, same encoding |

## Verification
The bench sweeps every combination of the event flags, the validity bits and a match or miss of the source register. This exposes priority mistakes: a design that lets a branch flush while a divide is still running would lose the branch target fetch. A load-use check that ignores the wait or busy flags would push a bubble into a held execute stage and drop an instruction. A second sweep covers all register triples on a small register file and catches a wrong youngest-producer choice, a missing register-0 exception, and forwarding from an invalid or non-writing stage. The sweeps also cover selects that change while execute is held or that survive an empty slot, since either would feed a stale operand into the ALU.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF = 2'd0,
        FWD_M  = 2'd1,
        FWD_WB = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic hold_if;
        logic hold_d;
        logic hold_e;
        logic hold_m;
        logic flush_if;
        logic flush_d;
        logic bubble_e;
        logic bubble_m;
        logic bubble_wb;
    } pipe_ctl_t;

    // The nearer producer carries the newer value of the register.
    function automatic fwd_sel_e pick_src(input logic hit_e, input logic hit_m);
        if (hit_e)      return FWD_M;
        else if (hit_m) return FWD_WB;
        else            return FWD_RF;
    endfunction

endpackage

// File: rtl/hz_fwd_pick.sv
`timescale 1ns/1ps
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit ZERO_SKIP = 1'b0
) (
    input  logic             use_i,
    input  logic [REG_W-1:0] rs_i,
    input  logic             e_valid_i,
    input  logic             e_we_i,
    input  logic [REG_W-1:0] e_rd_i,
    input  logic             m_valid_i,
    input  logic             m_we_i,
    input  logic [REG_W-1:0] m_rd_i,
    output fwd_sel_e         sel_o,
    output logic             e_hit_o
);
    logic eligible;
    logic hit_m;

    generate
        if (ZERO_SKIP) begin : g_skip
            assign eligible = use_i && (rs_i != '0);
        end else begin : g_plain
            assign eligible = use_i;
        end
    endgenerate

    assign e_hit_o = eligible && e_valid_i && e_we_i && (e_rd_i == rs_i);
    assign hit_m   = eligible && m_valid_i && m_we_i && (m_rd_i == rs_i);
    assign sel_o   = pick_src(e_hit_o, hit_m);
endmodule

// File: rtl/hz_stall_ctrl.sv
`timescale 1ns/1ps
module hz_stall_ctrl
    import hz_pkg::*;
(
    input  logic      load_use_i,
    input  logic      e_valid_i,
    input  logic      e_busy_i,
    input  logic      e_br_taken_i,
    input  logic      m_wait_i,
    output pipe_ctl_t ctl_o
);
    always_comb begin
        ctl_o = '0;
        if (m_wait_i) begin
            ctl_o.hold_if   = 1'b1;
            ctl_o.hold_d    = 1'b1;
            ctl_o.hold_e    = 1'b1;
            ctl_o.hold_m    = 1'b1;
            ctl_o.bubble_wb = 1'b1;
        end else if (e_busy_i) begin
            ctl_o.hold_if  = 1'b1;
            ctl_o.hold_d   = 1'b1;
            ctl_o.hold_e   = 1'b1;
            ctl_o.bubble_m = 1'b1;
        end else if (e_valid_i && e_br_taken_i) begin
            ctl_o.flush_if = 1'b1;
            ctl_o.flush_d  = 1'b1;
        end else if (load_use_i) begin
            ctl_o.hold_if  = 1'b1;
            ctl_o.hold_d   = 1'b1;
            ctl_o.bubble_e = 1'b1;
        end
    end
endmodule

// File: rtl/hz_ctrl.sv
`timescale 1ns/1ps
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit ZERO_SKIP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d_valid_i,
    input  logic [REG_W-1:0] d_rs1_i,
    input  logic             d_rs1_use_i,
    input  logic [REG_W-1:0] d_rs2_i,
    input  logic             d_rs2_use_i,
    input  logic             e_valid_i,
    input  logic [REG_W-1:0] e_rd_i,
    input  logic             e_we_i,
    input  logic             e_load_i,
    input  logic             e_busy_i,
    input  logic             e_br_taken_i,
    input  logic             m_valid_i,
    input  logic [REG_W-1:0] m_rd_i,
    input  logic             m_we_i,
    input  logic             m_wait_i,
    output logic             hold_if_o,
    output logic             hold_d_o,
    output logic             hold_e_o,
    output logic             hold_m_o,
    output logic             flush_if_o,
    output logic             flush_d_o,
    output logic             bubble_e_o,
    output logic             bubble_m_o,
    output logic             bubble_wb_o,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o
);
    localparam int NSRC = 2;

    logic [REG_W-1:0] src_rs  [NSRC];
    logic             src_use [NSRC];
    fwd_sel_e         sel_d   [NSRC];
    fwd_sel_e         sel_q   [NSRC];
    logic [NSRC-1:0]  e_hit;
    logic             load_use;
    logic             clear_sel;
    pipe_ctl_t        ctl;

    assign src_rs[0]  = d_rs1_i;
    assign src_rs[1]  = d_rs2_i;
    assign src_use[0] = d_rs1_use_i;
    assign src_use[1] = d_rs2_use_i;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            hz_fwd_pick #(
                .REG_W     (REG_W),
                .ZERO_SKIP (ZERO_SKIP)
            ) u_pick (
                .use_i     (src_use[i]),
                .rs_i      (src_rs[i]),
                .e_valid_i (e_valid_i),
                .e_we_i    (e_we_i),
                .e_rd_i    (e_rd_i),
                .m_valid_i (m_valid_i),
                .m_we_i    (m_we_i),
                .m_rd_i    (m_rd_i),
                .sel_o     (sel_d[i]),
                .e_hit_o   (e_hit[i])
            );
        end
    endgenerate

    // A load's data exists only after memory, one cycle too late for
    // the instruction right behind it.
    assign load_use = d_valid_i && e_load_i && (|e_hit);

    hz_stall_ctrl u_stall (
        .load_use_i   (load_use),
        .e_valid_i    (e_valid_i),
        .e_busy_i     (e_busy_i),
        .e_br_taken_i (e_br_taken_i),
        .m_wait_i     (m_wait_i),
        .ctl_o        (ctl)
    );

    assign clear_sel = !d_valid_i || ctl.flush_d || ctl.bubble_e;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (rst)
                sel_q[i] <= FWD_RF;
            else if (!ctl.hold_e)
                sel_q[i] <= clear_sel ? FWD_RF : sel_d[i];
        end
    end

    assign hold_if_o   = ctl.hold_if;
    assign hold_d_o    = ctl.hold_d;
    assign hold_e_o    = ctl.hold_e;
    assign hold_m_o    = ctl.hold_m;
    assign flush_if_o  = ctl.flush_if;
    assign flush_d_o   = ctl.flush_d;
    assign bubble_e_o  = ctl.bubble_e;
    assign bubble_m_o  = ctl.bubble_m;
    assign bubble_wb_o = ctl.bubble_wb;
    assign fwd_a_o     = sel_q[0];
    assign fwd_b_o     = sel_q[1];
endmodule

// File: rtl/hz_ctrl_chk.sv
`timescale 1ns/1ps
module hz_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       e_valid_i,
    input logic       e_load_i,
    input logic       e_busy_i,
    input logic       e_br_taken_i,
    input logic       m_wait_i,
    input logic       hold_if_o,
    input logic       hold_d_o,
    input logic       hold_e_o,
    input logic       hold_m_o,
    input logic       flush_if_o,
    input logic       flush_d_o,
    input logic       bubble_e_o,
    input logic       bubble_m_o,
    input logic       bubble_wb_o,
    input logic [1:0] fwd_a_o,
    input logic [1:0] fwd_b_o
);
    p_hold_chain_r8: assert property (@(posedge clk) disable iff (rst)
        hold_m_o |-> (hold_e_o && hold_d_o && hold_if_o));

    p_wait_only_r8: assert property (@(posedge clk) disable iff (rst)
        m_wait_i |-> (hold_m_o && bubble_wb_o && !flush_if_o && !flush_d_o
                      && !bubble_e_o && !bubble_m_o));

    p_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (e_busy_i && !m_wait_i) |-> (hold_e_o && hold_d_o && hold_if_o
                                     && !hold_m_o && bubble_m_o));

    p_branch_r9: assert property (@(posedge clk) disable iff (rst)
        (e_valid_i && e_br_taken_i && !e_busy_i && !m_wait_i)
            |-> (flush_if_o && flush_d_o && !hold_if_o && !hold_d_o));

    p_load_use_r6: assert property (@(posedge clk) disable iff (rst)
        bubble_e_o |-> (e_load_i && hold_d_o && hold_if_o && !hold_e_o));

    p_keep_sel_r10: assert property (@(posedge clk) disable iff (rst)
        hold_e_o |=> ($stable(fwd_a_o) && $stable(fwd_b_o)));

    p_clear_sel_r11: assert property (@(posedge clk) disable iff (rst)
        ((bubble_e_o || flush_d_o) && !hold_e_o)
            |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
endmodule

bind hz_ctrl hz_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .e_valid_i    (e_valid_i),
    .e_load_i     (e_load_i),
    .e_busy_i     (e_busy_i),
    .e_br_taken_i (e_br_taken_i),
    .m_wait_i     (m_wait_i),
    .hold_if_o    (hold_if_o),
    .hold_d_o     (hold_d_o),
    .hold_e_o     (hold_e_o),
    .hold_m_o     (hold_m_o),
    .flush_if_o   (flush_if_o),
    .flush_d_o    (flush_d_o),
    .bubble_e_o   (bubble_e_o),
    .bubble_m_o   (bubble_m_o),
    .bubble_wb_o  (bubble_wb_o),
    .fwd_a_o      (fwd_a_o),
    .fwd_b_o      (fwd_b_o)
);

// File: tb/hz_ctrl_tb.sv
`timescale 1ns/1ps
module hz_ctrl_tb_top;
    localparam int RW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic dv, u1, u2, ev, ewe, eld, ebusy, br, mv, mwe, mwait;
    logic [RW-1:0] rs1, rs2, erd, mrd;

    logic hif, hd, he, hm, fif, fd, be, bm, bwb;
    logic [1:0] fa, fb;
    logic zhif, zhd, zhe, zhm, zfif, zfd, zbe, zbm, zbwb;
    logic [1:0] zfa, zfb;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] efa, efb, ezfa, ezfb;

    hz_ctrl #(.REG_W(RW), .ZERO_SKIP(1'b0)) dut_i (
        .clk(clk), .rst(rst), .d_valid_i(dv), .d_rs1_i(rs1), .d_rs1_use_i(u1),
        .d_rs2_i(rs2), .d_rs2_use_i(u2), .e_valid_i(ev), .e_rd_i(erd), .e_we_i(ewe),
        .e_load_i(eld), .e_busy_i(ebusy), .e_br_taken_i(br), .m_valid_i(mv),
        .m_rd_i(mrd), .m_we_i(mwe), .m_wait_i(mwait),
        .hold_if_o(hif), .hold_d_o(hd), .hold_e_o(he), .hold_m_o(hm),
        .flush_if_o(fif), .flush_d_o(fd), .bubble_e_o(be), .bubble_m_o(bm),
        .bubble_wb_o(bwb), .fwd_a_o(fa), .fwd_b_o(fb));

    hz_ctrl #(.REG_W(RW), .ZERO_SKIP(1'b1)) dut_z (
        .clk(clk), .rst(rst), .d_valid_i(dv), .d_rs1_i(rs1), .d_rs1_use_i(u1),
        .d_rs2_i(rs2), .d_rs2_use_i(u2), .e_valid_i(ev), .e_rd_i(erd), .e_we_i(ewe),
        .e_load_i(eld), .e_busy_i(ebusy), .e_br_taken_i(br), .m_valid_i(mv),
        .m_rd_i(mrd), .m_we_i(mwe), .m_wait_i(mwait),
        .hold_if_o(zhif), .hold_d_o(zhd), .hold_e_o(zhe), .hold_m_o(zhm),
        .flush_if_o(zfif), .flush_d_o(zfd), .bubble_e_o(zbe), .bubble_m_o(zbm),
        .bubble_wb_o(zbwb), .fwd_a_o(zfa), .fwd_b_o(zfb));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [1:0] pick(input logic u, input logic [RW-1:0] rs, input logic zs);
        logic ok, he_hit, hm_hit;
        ok     = u && !(zs && rs == '0);
        he_hit = ok && ev && ewe && (rs == erd);
        hm_hit = ok && mv && mwe && (rs == mrd);
        return he_hit ? 2'd1 : (hm_hit ? 2'd2 : 2'd0);
    endfunction

    // {hold_if,hold_d,hold_e,hold_m,flush_if,flush_d,bubble_e,bubble_m,bubble_wb}
    function automatic logic [8:0] exp_ctl();
        logic lu;
        lu = dv && ev && eld && ewe && ((u1 && rs1 == erd) || (u2 && rs2 == erd));
        if (mwait)         return 9'b1111_0000_1;
        else if (ebusy)    return 9'b1110_0001_0;
        else if (ev && br) return 9'b0000_1100_0;
        else if (lu)       return 9'b1100_0010_0;
        else               return 9'b0;
    endfunction

    function automatic string ctl_tag(input logic [8:0] e);
        if (mwait)      return "R8";
        else if (ebusy) return "R7";
        else if (e[4])  return "R9";
        else if (e[2])  return "R6";
        else            return "R9";
    endfunction

    function automatic string sel_tag(input logic [8:0] e, input logic [1:0] v);
        if (e[6])                      return "R10";
        else if (!dv || e[3] || e[2])  return "R11";
        else if (v == 2'd1)            return "R2";
        else if (v == 2'd2)            return "R3";
        else                           return "R4";
    endfunction

    task automatic step();
        logic [8:0] ec;
        string ta, tb, tz;
        #1;
        ec = exp_ctl();
        chk(ctl_tag(ec), {hif, hd, he, hm, fif, fd, be, bm, bwb}, ec);
        if (!ec[6]) begin
            if (!dv || ec[3] || ec[2]) begin
                efa = 0; efb = 0; ezfa = 0; ezfb = 0;
            end else begin
                efa  = pick(u1, rs1, 1'b0);
                efb  = pick(u2, rs2, 1'b0);
                ezfa = pick(u1, rs1, 1'b1);
                ezfb = pick(u2, rs2, 1'b1);
            end
        end
        ta = sel_tag(ec, efa);
        tb = sel_tag(ec, efb);
        tz = (rs1 == '0 && u1 && !ec[6]) ? "R5" : sel_tag(ec, ezfa);
        @(posedge clk);
        @(negedge clk);
        chk(ta, fa, efa);
        chk(tb, fb, efb);
        chk(tz, zfa, ezfa);
        chk(tb, zfb, ezfb);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        {dv, u1, u2, ev, ewe, eld, ebusy, br, mv, mwe, mwait} = '0;
        rs1 = 0; rs2 = 0; erd = 0; mrd = 0;
        efa = 0; efb = 0; ezfa = 0; ezfb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", {fa, fb, zfa, zfb}, 8'h00);

        // Sweep of event flags, validity and source match (R6..R11).
        for (int k = 0; k < 512; k++) begin
            dv = k[0]; u1 = k[1]; ev = k[2]; ewe = k[3]; eld = k[4];
            ebusy = k[5]; br = k[6]; mwait = k[7];
            erd = 2'd1; mrd = 2'd2; mv = 1'b1; mwe = 1'b1;
            rs1 = k[8] ? 2'd1 : 2'd3;
            u2 = 1'b1; rs2 = 2'd2;
            step();
        end

        // Sweep of register triples for forwarding (R2..R5).
        {eld, ebusy, br, mwait} = '0;
        dv = 1'b1; u1 = 1'b1; u2 = 1'b0; rs2 = 2'd0;
        for (int k = 0; k < 1024; k++) begin
            rs1 = k[1:0]; erd = k[3:2]; mrd = k[5:4];
            ewe = k[6]; mwe = k[7]; ev = k[8]; mv = k[9];
            step();
        end

        // Load-use then forward from write-back (R6, R3).
        ev = 1; ewe = 1; eld = 1; erd = 2'd3; mv = 0; mwe = 0;
        rs1 = 2'd3; u1 = 1; u2 = 0;
        step();
        eld = 0; ev = 0; mv = 1; mwe = 1; mrd = 2'd3;
        step();
        chk("R3", fa, 2'd2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule